// File: doc/BRIEF.md
# Watchdog Challenge Generator and Answer Checker

This block serves a question/answer watchdog. It keeps an 8-bit pseudo-random challenge word in a linear feedback shift register, and the processor can read that word at any time. The processor answers by writing an 8-bit word. The block compares the answer with a fixed arithmetic and bitwise transform of the current challenge and reports the verdict as a one-cycle pulse. The challenge moves to its next value only when the answer is correct. A wrong answer leaves the same question in place.

While the surrounding watchdog holds the block in its initialisation phase, the processor may load its own seed. A seed of zero would lock the register, so the block replaces it with the reset value. Window timing, error counting and bus decoding belong to the surrounding logic.

Top module: `wd_challenge`

## Requirements
- R1: After reset, `challenge` reads 0xB2 and neither result pulse is high.
- R2: A seed write (`seedWrEn` high) while `initPhase` is high loads `seedData` into `challenge` at the next clock edge.
- R3: A seed write of 0x00 during initialisation loads 0xB2 instead.
- R4: A seed write while `initPhase` is low is ignored, and `challenge` keeps its value.
- R5: The expected answer is formed at 16-bit width as ((NOT (challenge*4 + 6 - 4)) >> 2), keeping the low 8 bits. This equals the bitwise complement of the challenge, and it gives 0x4D for 0xB2. Every other answer value is wrong.
- R6: A correct answer advances `challenge` one step at the next edge. The word shifts toward the MSB, and the new bit 0 is bit7 XOR bit5 XOR bit4 XOR bit3 (polynomial x^8+x^6+x^5+x^4+1).
- R7: A wrong answer leaves `challenge` unchanged.
- R8: Each answer strobe gives exactly one of `resultOk` / `resultBad`, high for the one cycle after the strobe edge. With no strobe, neither is high.
- R9: Starting from 0xB2, 255 consecutive correct answers visit 255 nonzero values and return to 0xB2.
- R10: If a seed write is accepted in the same cycle as an answer strobe, the seed is loaded. The answer is still judged against the challenge held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| initPhase | input | 1 | High while the watchdog is initialising |
| seedWrEn | input | 1 | Seed write strobe |
| seedData | input | 8 | Seed value |
| ansWrEn | input | 1 | Answer write strobe |
| ansData | input | 8 | Answer value |
| challenge | output | 8 | Current challenge word |
| resultOk | output | 1 | Pulse: the last answer was correct |
| resultBad | output | 1 | Pulse: the last answer was wrong |

## Verification
Every input is registered once. A seed or answer presented before an edge therefore shows on `challenge`, `resultOk` and `resultBad` straight after that edge, and one cycle later the pulses have dropped again. The bench drives inputs on the falling edge and samples on the next falling edge, which places each sample exactly one register stage after its stimulus. It checks the pulses fall again on the falling edge after that. The sweeps cover every seed value, every answer value against one challenge, and a wrong-then-right pair at all 255 states of the sequence.

// File: rtl/wd_challenge_pkg.sv
package wd_challenge_pkg;
  localparam int unsigned WORD_W = 8;
  localparam logic [WORD_W-1:0] DEFAULT_SEED = 8'hB2;
  // taps at bits 7,5,4,3 for x^8+x^6+x^5+x^4+1
  localparam logic [WORD_W-1:0] FIB_TAPS = 8'b1011_1000;

  typedef struct packed {
    logic loadSeed;
    logic advance;
  } chalStrobe_t;
endpackage

// File: rtl/wd_challenge_ctrl.sv
module wd_challenge_ctrl
  import wd_challenge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        initPhase,
  input  logic        seedWrEn,
  input  logic        ansWrEn,
  input  logic        answerMatch,
  output chalStrobe_t strobe,
  output logic        resultOk,
  output logic        resultBad
);
  logic seedAccepted;

  assign seedAccepted = seedWrEn & initPhase;

  always_comb begin
    strobe = '0;
    if (seedAccepted) begin
      strobe.loadSeed = 1'b1;
    end else if (ansWrEn && answerMatch) begin
      strobe.advance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultOk  <= 1'b0;
      resultBad <= 1'b0;
    end else begin
      resultOk  <= ansWrEn & answerMatch;
      resultBad <= ansWrEn & ~answerMatch;
    end
  end
endmodule

// File: rtl/wd_challenge_dp.sv
module wd_challenge_dp
  import wd_challenge_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter logic [W-1:0] RESET_SEED = DEFAULT_SEED,
  parameter logic [W-1:0] TAPS = FIB_TAPS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  chalStrobe_t strobe,
  input  logic [W-1:0] seedData,
  input  logic [W-1:0] ansData,
  output logic [W-1:0] challenge,
  output logic         answerMatch
);
  localparam int unsigned XW = 2 * W;

  logic [W-1:0]  state;
  logic [W-1:0]  nextState;
  logic [W-1:0]  seedSafe;
  logic          feedback;
  logic [XW-1:0] widened;
  logic [XW-1:0] scaled;
  logic [XW-1:0] inverted;
  logic [W-1:0]  expected;

  // transform: ((~(c*4 + 6 - 4)) >> 2), low W bits
  always_comb begin
    widened  = {{W{1'b0}}, state};
    scaled   = (widened << 2) + XW'(6) - XW'(4);
    inverted = ~scaled;
    expected = W'(inverted >> 2);
  end

  assign answerMatch = (ansData == expected);

  assign feedback  = ^(state & TAPS);
  assign nextState = {state[W-2:0], feedback};
  assign seedSafe  = (seedData == '0) ? RESET_SEED : seedData;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RESET_SEED;
    end else if (strobe.loadSeed) begin
      state <= seedSafe;
    end else if (strobe.advance) begin
      state <= nextState;
    end
  end

  assign challenge = state;
endmodule

// File: rtl/wd_challenge.sv
module wd_challenge
  import wd_challenge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       initPhase,
  input  logic       seedWrEn,
  input  logic [7:0] seedData,
  input  logic       ansWrEn,
  input  logic [7:0] ansData,
  output logic [7:0] challenge,
  output logic       resultOk,
  output logic       resultBad
);
  chalStrobe_t strobe;
  logic        answerMatch;

  wd_challenge_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .initPhase   (initPhase),
    .seedWrEn    (seedWrEn),
    .ansWrEn     (ansWrEn),
    .answerMatch (answerMatch),
    .strobe      (strobe),
    .resultOk    (resultOk),
    .resultBad   (resultBad)
  );

  wd_challenge_dp #(
    .W          (WORD_W),
    .RESET_SEED (DEFAULT_SEED),
    .TAPS       (FIB_TAPS)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .seedData    (seedData),
    .ansData     (ansData),
    .challenge   (challenge),
    .answerMatch (answerMatch)
  );
endmodule

// File: rtl/wd_challenge_sva.sv
module wd_challenge_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       initPhase,
  input logic       seedWrEn,
  input logic       ansWrEn,
  input logic [7:0] challenge,
  input logic       resultOk,
  input logic       resultBad
);
  // R8: never both verdicts
  a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({resultOk, resultBad}) <= 1);

  // R8: a strobe yields a verdict next cycle
  a_r8_strobe_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ansWrEn |=> (resultOk || resultBad));

  // R8: no strobe, no verdict
  a_r8_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !ansWrEn |=> !(resultOk || resultBad));

  // R9 / R3: the register never holds zero
  a_r9_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    challenge != 8'h00);

  // R4: seed outside init with no answer leaves challenge alone
  a_r4_seed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (seedWrEn && !initPhase && !ansWrEn) |=> $stable(challenge));

  // R7: wrong answer without seed load holds the challenge
  a_r7_hold_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (ansWrEn && !(seedWrEn && initPhase)) |=> (resultBad -> $stable(challenge)));

  // R6: correct answer without seed load changes the challenge
  a_r6_move_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (ansWrEn && !(seedWrEn && initPhase)) |=> (resultOk -> !$stable(challenge)));
endmodule

bind wd_challenge wd_challenge_sva chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .initPhase (initPhase),
  .seedWrEn  (seedWrEn),
  .ansWrEn   (ansWrEn),
  .challenge (challenge),
  .resultOk  (resultOk),
  .resultBad (resultBad)
);

// File: tb/wd_challenge_tb.sv
module wd_challenge_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       initPhase = 1'b0;
  logic       seedWrEn = 1'b0;
  logic [7:0] seedData = 8'h00;
  logic       ansWrEn = 1'b0;
  logic [7:0] ansData = 8'h00;
  logic [7:0] challenge;
  logic       resultOk;
  logic       resultBad;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wd_challenge dut_i (
    .clk(clk), .rst_n(rst_n), .initPhase(initPhase),
    .seedWrEn(seedWrEn), .seedData(seedData),
    .ansWrEn(ansWrEn), .ansData(ansData),
    .challenge(challenge), .resultOk(resultOk), .resultBad(resultBad)
  );

  function automatic logic [7:0] stepModel(input logic [7:0] c);
    return {c[6:0], c[7] ^ c[5] ^ c[4] ^ c[3]};
  endfunction

  function automatic logic [7:0] answerModel(input logic [7:0] c);
    logic [15:0] t;
    t = ~(({8'h00, c} * 16'd4) + 16'd6 - 16'd4);
    return t[9:2];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one answer; returns after the verdict edge, sampled mid-cycle
  task automatic answer(input logic [7:0] a);
    @(negedge clk);
    ansWrEn = 1'b1; ansData = a;
    @(negedge clk);
    ansWrEn = 1'b0;
  endtask

  task automatic seed(input logic init, input logic [7:0] s);
    @(negedge clk);
    initPhase = init; seedWrEn = 1'b1; seedData = s;
    @(negedge clk);
    seedWrEn = 1'b0; initPhase = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    logic [7:0] start;
    logic       nonzero;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset challenge", challenge, 8'hB2);
    check("R1 reset pulses", {resultOk, resultBad}, 2'b00);

    // R5: known pair and model agreement
    check("R5 model 0xB2", answerModel(8'hB2), 8'h4D);

    // R5/R7/R8: sweep every answer against 0xB2
    for (int a = 0; a < 256; a++) begin
      logic expOk;
      expOk = (8'(a) == answerModel(8'hB2));
      if (!expOk) begin
        answer(8'(a));
        check("R8 bad pulse", {resultOk, resultBad}, 2'b01);
        check("R7 hold", challenge, 8'hB2);
        @(negedge clk);
        check("R8 pulse one cycle", {resultOk, resultBad}, 2'b00);
      end
    end

    // R2/R3: every seed in init
    for (int s = 0; s < 256; s++) begin
      seed(1'b1, 8'(s));
      check(s == 0 ? "R3 zero seed" : "R2 seed load", challenge, s == 0 ? 8'hB2 : 8'(s));
    end

    // R4: seed outside init ignored
    seed(1'b1, 8'h5A);
    seed(1'b0, 8'h33);
    check("R4 seed ignored", challenge, 8'h5A);
    check("R4 no pulse", {resultOk, resultBad}, 2'b00);

    // R10: seed with answer in the same cycle
    @(negedge clk);
    initPhase = 1'b1; seedWrEn = 1'b1; seedData = 8'h77;
    ansWrEn = 1'b1; ansData = answerModel(8'h5A);
    @(negedge clk);
    initPhase = 1'b0; seedWrEn = 1'b0; ansWrEn = 1'b0;
    check("R10 seed wins", challenge, 8'h77);
    check("R10 verdict on old", {resultOk, resultBad}, 2'b10);

    // R6/R7/R9: full cycle with a wrong then right answer at each state
    seed(1'b1, 8'hB2);
    start = challenge;
    nonzero = 1'b1;
    for (int i = 0; i < 255; i++) begin
      c = challenge;
      if (c == 8'h00) nonzero = 1'b0;
      if (i > 0 && c == start) nonzero = 1'b0;
      answer(answerModel(c) ^ 8'h01);
      check("R7 hold wrong", challenge, c);
      answer(answerModel(c));
      check("R8 ok pulse", {resultOk, resultBad}, 2'b10);
      check("R6 advance", challenge, stepModel(c));
    end
    check("R9 period 255", challenge, start);
    check("R9 nonzero distinct", nonzero, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule